// File: doc/BRIEF.md
# Branch Target Address Generator

This block computes the next program-counter value for every branch form of an 8-bit controller core. It also computes the code-read address for the indexed constant loads. A request carries the current PC, the length of the instruction, two operand bytes, the accumulator, the data pointer and a kind code. The block turns these into one 16-bit address, together with a flag that says whether the address is a branch destination or a code-read address.

Requests enter on a valid/ready handshake. Each accepted request is computed combinationally and captured in an output register. From there it is offered on a second valid/ready handshake.

The output register holds at most one result. A request is accepted when the register is empty, or when its current result is being taken in the same cycle. While the consumer holds ready low, the result and its flags stay frozen and no new request is accepted. Evaluating branch conditions and pushing return addresses belong to the surrounding core.

Top module: `bta_gen`

## Requirements
- R1: After reset, `tgt_valid` is low and `in_ready` is high.
- R2: Kind 0 (relative) gives PC + length + the sign-extended `opnd0` and raises `tgt_take`, so the offset reaches from -128 to +127 around the following instruction.
- R3: Kind 1 (in-page) gives an address whose bits 15..11 are taken from PC + length, whose bits 10..8 are `opnd0[2:0]` and whose bits 7..0 are `opnd1`, and raises `tgt_take`.
- R4: Kind 2 (long) gives `{opnd0, opnd1}`, with `opnd0` as the high byte, and raises `tgt_take`.
- R5: Kind 3 (indexed jump) gives the data pointer plus the zero-extended accumulator and raises `tgt_take`.
- R6: Kind 4 (code read through the data pointer) gives the data pointer plus the zero-extended accumulator, raises `tgt_fetch` and leaves `tgt_take` low.
- R7: Kind 5 (code read through the PC) gives PC + length + the zero-extended accumulator and raises `tgt_fetch`.
- R8: Kinds 6 and 7 are accepted but produce no result: `tgt_valid` is low in the following cycle unless an earlier result is still stalled.
- R9: A result appears in the cycle after its request is accepted. While `tgt_valid` is high, exactly one of `tgt_take` and `tgt_fetch` is high. While `tgt_valid` is low, both are low.
- R10: `in_ready` equals `!tgt_valid || tgt_ready`. While `tgt_valid` is high and `tgt_ready` is low, the address and flags hold their values into the next cycle.
- R11: All address sums wrap modulo 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle if valid |
| req_kind | input | 3 | Kind code, 0 to 7 |
| pc | input | 16 | Address of the current instruction |
| len | input | 2 | Instruction length in bytes |
| opnd0 | input | 8 | First operand byte |
| opnd1 | input | 8 | Second operand byte |
| acc | input | 8 | Accumulator, unsigned |
| dptr | input | 16 | Data pointer |
| tgt_valid | output | 1 | Result present |
| tgt_ready | input | 1 | Consumer takes the result |
| tgt_addr | output | 16 | Computed address |
| tgt_take | output | 1 | Result is a branch destination |
| tgt_fetch | output | 1 | Result is a code-read address |

## Verification
In one cycle the output register can hand its result to the consumer while it also captures the next request. When that happens, the old address must leave and the new one must arrive on the next clock, with neither lost nor repeated.

The bench provokes this by holding requests back to back while toggling `tgt_ready` at random, so drain-and-load cycles mix with stalls. A per-cycle reference queue judges the outcome against the address, flags and `in_ready` at each falling edge. Reserved kinds are mixed into the same stream to confirm they are consumed without occupying a slot.

// File: rtl/bta_pkg.sv
package bta_pkg;
  typedef enum logic [2:0] {
    K_REL  = 3'd0,
    K_PAGE = 3'd1,
    K_LONG = 3'd2,
    K_IJMP = 3'd3,
    K_CDPT = 3'd4,
    K_CPC  = 3'd5,
    K_RSV6 = 3'd6,
    K_RSV7 = 3'd7
  } kind_e;

  typedef struct packed {
    logic take;
    logic fetch;
  } flags_t;
endpackage

// File: rtl/bta_adder.sv
module bta_adder #(
  parameter int AW = 16,
  parameter int OW = 8,
  parameter bit SEXT = 1'b0
) (
  input  logic [AW-1:0] base,
  input  logic [OW-1:0] off,
  output logic [AW-1:0] sum
);
  logic [AW-1:0] off_ext;
  generate
    if (SEXT) begin : g_sign
      assign off_ext = {{(AW-OW){off[OW-1]}}, off};
    end else begin : g_zero
      assign off_ext = {{(AW-OW){1'b0}}, off};
    end
  endgenerate
  assign sum = base + off_ext;
endmodule

// File: rtl/bta_select.sv
module bta_select
  import bta_pkg::*;
#(
  parameter int DW = 8,
  parameter int PAGE_BITS = 11,
  localparam int AW = 2 * DW
) (
  input  logic [2:0]    kind,
  input  logic [AW-1:0] pc_next,
  input  logic [AW-1:0] rel_sum,
  input  logic [AW-1:0] dp_sum,
  input  logic [AW-1:0] pcacc_sum,
  input  logic [DW-1:0] opnd0,
  input  logic [DW-1:0] opnd1,
  output logic [AW-1:0] addr,
  output flags_t        flags,
  output logic          ok
);
  logic [AW-1:0] opcat;
  logic [AW-1:0] page_addr;
  assign opcat     = {opnd0, opnd1};
  assign page_addr = {pc_next[AW-1:PAGE_BITS], opcat[PAGE_BITS-1:0]};

  always_comb begin
    addr  = '0;
    flags = '0;
    ok    = 1'b1;
    unique case (kind_e'(kind))
      K_REL:  begin addr = rel_sum;   flags.take  = 1'b1; end
      K_PAGE: begin addr = page_addr; flags.take  = 1'b1; end
      K_LONG: begin addr = opcat;     flags.take  = 1'b1; end
      K_IJMP: begin addr = dp_sum;    flags.take  = 1'b1; end
      K_CDPT: begin addr = dp_sum;    flags.fetch = 1'b1; end
      K_CPC:  begin addr = pcacc_sum; flags.fetch = 1'b1; end
      default: ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/bta_hold.sv
module bta_hold
  import bta_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          ld_ok,
  input  logic [AW-1:0] ld_addr,
  input  flags_t        ld_flags,
  output logic          out_valid,
  output logic [AW-1:0] out_addr,
  output flags_t        out_flags
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_flags <= '0;
    end else if (load) begin
      out_valid <= ld_ok;
      out_addr  <= ld_addr;
      out_flags <= ld_ok ? ld_flags : '0;
    end
  end
endmodule

// File: rtl/bta_gen.sv
module bta_gen
  import bta_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 2,
  parameter int PAGE_BITS = 11,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] pc,
  input  logic [LW-1:0] len,
  input  logic [DW-1:0] opnd0,
  input  logic [DW-1:0] opnd1,
  input  logic [DW-1:0] acc,
  input  logic [AW-1:0] dptr,
  output logic          tgt_valid,
  input  logic          tgt_ready,
  output logic [AW-1:0] tgt_addr,
  output logic          tgt_take,
  output logic          tgt_fetch
);
  logic [AW-1:0] pc_next, rel_sum, dp_sum, pcacc_sum, sel_addr;
  flags_t        sel_flags, out_flags;
  logic          sel_ok;

  bta_adder #(.AW(AW), .OW(LW), .SEXT(1'b0)) u_pcn (.base(pc),      .off(len),   .sum(pc_next));
  bta_adder #(.AW(AW), .OW(DW), .SEXT(1'b1)) u_rel (.base(pc_next), .off(opnd0), .sum(rel_sum));
  bta_adder #(.AW(AW), .OW(DW), .SEXT(1'b0)) u_dpa (.base(dptr),    .off(acc),   .sum(dp_sum));
  bta_adder #(.AW(AW), .OW(DW), .SEXT(1'b0)) u_pca (.base(pc_next), .off(acc),   .sum(pcacc_sum));

  bta_select #(.DW(DW), .PAGE_BITS(PAGE_BITS)) u_sel (
    .kind(req_kind), .pc_next(pc_next), .rel_sum(rel_sum), .dp_sum(dp_sum),
    .pcacc_sum(pcacc_sum), .opnd0(opnd0), .opnd1(opnd1),
    .addr(sel_addr), .flags(sel_flags), .ok(sel_ok)
  );

  assign in_ready = !tgt_valid || tgt_ready;

  bta_hold #(.AW(AW)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(in_ready), .ld_ok(in_valid && sel_ok),
    .ld_addr(sel_addr), .ld_flags(sel_flags),
    .out_valid(tgt_valid), .out_addr(tgt_addr), .out_flags(out_flags)
  );

  assign tgt_take  = out_flags.take;
  assign tgt_fetch = out_flags.fetch;
endmodule

// File: rtl/bta_gen_chk.sv
module bta_gen_chk #(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [2:0]    req_kind,
  input logic [DW-1:0] opnd0,
  input logic [DW-1:0] opnd1,
  input logic [AW-1:0] dptr,
  input logic [DW-1:0] acc,
  input logic          tgt_valid,
  input logic          tgt_ready,
  input logic [AW-1:0] tgt_addr,
  input logic          tgt_take,
  input logic          tgt_fetch
);
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid |-> $onehot({tgt_take, tgt_fetch}));  // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_valid |-> !tgt_take && !tgt_fetch);  // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid && !tgt_ready |=> tgt_valid && $stable(tgt_addr) && $stable(tgt_take));  // R10
  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_valid |-> in_ready);  // R10
  AST_LONG_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && req_kind == 3'd2 |=>
      tgt_valid && tgt_take && tgt_addr == {$past(opnd0), $past(opnd1)});  // R4
  AST_CODE_DPTR: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && req_kind == 3'd4 |=>
      tgt_fetch && !tgt_take && tgt_addr == $past(dptr) + AW'($past(acc)));  // R6
endmodule

bind bta_gen bta_gen_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .req_kind(req_kind), .opnd0(opnd0), .opnd1(opnd1), .dptr(dptr), .acc(acc),
  .tgt_valid(tgt_valid), .tgt_ready(tgt_ready), .tgt_addr(tgt_addr),
  .tgt_take(tgt_take), .tgt_fetch(tgt_fetch)
);

// File: tb/sim_bta_gen.sv
module sim_bta_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  req_kind = '0;
  logic [15:0] pc = '0;
  logic [1:0]  len = 2'd1;
  logic [7:0]  opnd0 = '0, opnd1 = '0, acc = '0;
  logic [15:0] dptr = '0;
  logic        tgt_valid, tgt_ready = 1'b0;
  logic [15:0] tgt_addr;
  logic        tgt_take, tgt_fetch;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bta_gen u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .req_kind(req_kind), .pc(pc), .len(len), .opnd0(opnd0), .opnd1(opnd1),
    .acc(acc), .dptr(dptr), .tgt_valid(tgt_valid), .tgt_ready(tgt_ready),
    .tgt_addr(tgt_addr), .tgt_take(tgt_take), .tgt_fetch(tgt_fetch)
  );

  always #10 clk = ~clk;

  // expected results: {take, fetch, addr}
  logic [17:0] q[$];
  string       tq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit model(input int k, input int p, input int l, input int o0,
                               input int o1, input int a, input int d,
                               output logic [17:0] r, output string tag);
    int nx = p + l;
    int v;
    model = 1'b1;
    case (k)
      0: begin v = nx + (o0 > 127 ? o0 - 256 : o0); r = {2'b10, 16'(v & 65535)}; tag = "R2"; end
      1: begin v = (nx & 16'hF800) | ((o0 & 7) * 256) | o1; r = {2'b10, 16'(v & 65535)}; tag = "R3"; end
      2: begin v = o0 * 256 + o1; r = {2'b10, 16'(v)}; tag = "R4"; end
      3: begin v = d + a; r = {2'b10, 16'(v & 65535)}; tag = "R5"; end
      4: begin v = d + a; r = {2'b01, 16'(v & 65535)}; tag = "R6"; end
      5: begin v = nx + a; r = {2'b01, 16'(v & 65535)}; tag = "R7"; end
      default: begin r = '0; tag = "R8"; model = 1'b0; end
    endcase
  endfunction

  task automatic set_req(input int k, input int p, input int l, input int o0,
                         input int o1, input int a, input int d);
    req_kind = 3'(k); pc = 16'(p); len = 2'(l); opnd0 = 8'(o0); opnd1 = 8'(o1);
    acc = 8'(a); dptr = 16'(d);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tgt_valid == 1'b0, "R1", "tgt_valid in reset", tgt_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tgt_valid == 1'b0, "R1", "tgt_valid after reset", tgt_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    for (int i = 0; i < 3000; i++) begin
      logic [17:0] e;
      string       tg;
      bit          pop, push, has;
      // compare against the model at the falling edge
      has = q.size() > 0;
      chk(tgt_valid == has, has ? tq[0] : "R8", "tgt_valid", tgt_valid, has);
      if (has && tgt_valid) begin
        chk(tgt_addr == q[0][15:0], tq[0], "tgt_addr", tgt_addr, q[0][15:0]);
        chk({tgt_take, tgt_fetch} == q[0][17:16], "R9", "take/fetch", {tgt_take, tgt_fetch}, q[0][17:16]);
      end else if (!tgt_valid) begin
        chk({tgt_take, tgt_fetch} == 2'b00, "R9", "idle flags", {tgt_take, tgt_fetch}, 0);
      end
      // drive the next cycle's stimulus
      in_valid = 1'b1;
      if (i < 16) begin
        tgt_ready = (i % 4 != 1);  // R10 stalls in the directed part
        case (i)
          0:  set_req(0, 16'h8000, 2, 8'h3E, 0, 0, 0);        // relative forward
          1:  set_req(0, 16'h0010, 2, 8'h80, 0, 0, 0);        // R11 backward wrap below zero
          2:  set_req(0, 16'hFFF0, 2, 8'h7F, 0, 0, 0);        // R11 forward wrap
          3:  set_req(1, 16'h07FE, 2, 8'hFD, 8'h34, 0, 0);    // page taken after advance
          4:  set_req(1, 16'h1234, 2, 8'h02, 8'hAB, 0, 0);
          5:  set_req(2, 16'h0000, 3, 8'hBE, 8'hEF, 0, 0);
          6:  set_req(3, 16'h0000, 1, 0, 0, 8'hFF, 16'hFFFF); // R11 indexed wrap
          7:  set_req(4, 16'h0000, 1, 0, 0, 8'h80, 16'h1000);
          8:  set_req(5, 16'hFFFF, 1, 0, 0, 8'h10, 0);        // R11 pc wrap
          9:  set_req(6, 16'h4444, 1, 0, 0, 0, 0);            // reserved
          10: set_req(7, 16'h4444, 1, 0, 0, 0, 0);            // reserved
          11: set_req(2, 16'h0000, 3, 8'h00, 8'h00, 0, 0);
          default: set_req(i % 6, 16'h0100 * i, 1 + i % 3, 8'h81, 8'h11, 8'hC3, 16'hF00F);
        endcase
      end else begin
        in_valid  = ($urandom % 5) != 0;
        tgt_ready = ($urandom % 3) != 0;
        set_req($urandom % 8, $urandom % 65536, 1 + $urandom % 3, $urandom % 256,
                $urandom % 256, $urandom % 256, $urandom % 65536);
      end
      #1;
      chk(in_ready == (!tgt_valid || tgt_ready), "R10", "in_ready", in_ready, !tgt_valid || tgt_ready);
      pop  = tgt_valid && tgt_ready;
      push = in_valid && in_ready;
      if (pop && q.size() > 0) begin
        void'(q.pop_front());
        void'(tq.pop_front());
      end
      if (push && model(req_kind, pc, len, opnd0, opnd1, acc, dptr, e, tg)) begin
        q.push_back(e);
        tq.push_back(tg);
      end
      @(negedge clk);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule